// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a single-slot watchdog with a register interface. Software programs a configuration word that holds a mode, a 16-bit reload length, a management-interrupt enable and a 24-bit down-counter. A prescaler produces one counter tick every `PRESCALE` clock cycles (1024 by default). When a tick finds the counter at zero, the watchdog expires. Depending on the mode, successive expiries raise an application-core interrupt, then a pulse to a management processor, then a one-cycle reset request.

Software keeps the system alive by writing 1 to the slot's poke address. A poke reloads the counter from the length field and returns the escalation to its first stage. The core interrupt has a write-1-to-clear pending bit and an enable bit. The enable is changed through separate write-1 set and clear addresses. The slot index is a parameter: it selects which register addresses and which bit of the shared pending and enable words this slot answers to.

Top module: `stage_watchdog`

## Requirements
- R1: A write to the configuration address (8 × `TIMER_IDX`) loads mode from bits [1:0], the management-interrupt enable from bit 2, the length from bits [19:4] and the counter from bits [43:20]. It also clears the prescaler and the stage. A read of that address returns the same fields, with the live counter value in bits [43:20].
- R2: In mode 0 the prescaler and counter hold their values, and no expiry occurs.
- R3: With a nonzero mode, the counter decrements once every `PRESCALE` cycles. An expiry happens on the tick that finds the counter at zero. After a configuration write with count C, the first expiry lands (C+1) × `PRESCALE` cycles later.
- R4: After each non-final expiry, and on a poke, the counter is reloaded with the length in its upper 16 bits and zeros in its lower 8 bits, and the prescaler restarts. The next expiry therefore lands (256 × length + 1) × `PRESCALE` cycles later.
- R5: A write at address 0x10000 + 8 × `TIMER_IDX` with data bit 0 set reloads the counter and returns the stage to the first stage. With bit 0 clear, the write has no effect. A poke or configuration write in the same cycle as an expiry cancels that expiry.
- R6: In mode 3, the first expiry sets the pending bit, the second pulses `mgmtIrq` for one cycle, and the third pulses `rstReq` for one cycle. The reset request also sets the mode and counter to 0, so the watchdog stays idle until it is reconfigured.
- R7: With the management-interrupt enable (configuration bit 2) clear, the second expiry in mode 3 gives no `mgmtIrq` pulse. The stage still advances, so the third expiry still requests reset.
- R8: In mode 1, every expiry sets the pending bit and never pulses `mgmtIrq` or `rstReq`. In mode 2, the first expiry sets pending and every later expiry pulses `mgmtIrq`, never `rstReq`. In both modes the mode is kept.
- R9: The pending word at 0x200 holds this slot's pending bit at position `TIMER_IDX`. Writing 1 there clears it. A hardware set in the same cycle wins over the clear.
- R10: Writing 1 at bit `TIMER_IDX` of address 0x218 sets the enable, and writing 1 at that bit of 0x210 clears it. Both addresses read back the enable at bit `TIMER_IDX`. `coreIrq` is high exactly when pending and enable are both set.
- R11: After reset, all outputs and all register reads are zero. Reads of unmapped addresses, including the poke address, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 64 | Write data |
| busRdata | output | 64 | Read data, combinational from the address in the same cycle |
| coreIrq | output | 1 | Application-core interrupt level (pending AND enable) |
| mgmtIrq | output | 1 | One-cycle management-processor interrupt pulse |
| rstReq | output | 1 | One-cycle reset request pulse |

## Verification
Every register update and output pulse appears one clock edge after the bus write or expiry that causes it. Read data is valid in the same cycle as the read strobe.

Expiry times are fixed by arithmetic:
- the first expiry comes (C+1) × `PRESCALE` edges after the configuration write;
- each later expiry comes (256 × length + 1) × `PRESCALE` edges after the one before.

The bench counts rising edges. At each falling edge it records the edge number at which each output first shows an event, and compares that number against the computed offset from the write edge. The same-cycle clear-versus-set race is produced by placing a pending-clear write exactly on the computed expiry edge.

// File: rtl/swd_pkg.sv
package swd_pkg;

  localparam int REG_W    = 64;
  localparam int MODE_LSB = 0;
  localparam int MGMT_BIT = 2;
  localparam int LEN_LSB  = 4;

  localparam logic [1:0] MODE_STOP = 2'd0;
  localparam logic [1:0] MODE_CORE = 2'd1;
  localparam logic [1:0] MODE_TWO  = 2'd2;
  localparam logic [1:0] MODE_FULL = 2'd3;

  typedef enum logic [1:0] {
    STG_CORE  = 2'd0,
    STG_MGMT  = 2'd1,
    STG_FINAL = 2'd2
  } swdStage_t;

  typedef struct packed {
    logic cfgLoad;
    logic reload;
    logic goIdle;
  } swdStrobe_t;

endpackage

// File: rtl/swd_datapath.sv
module swd_datapath
  import swd_pkg::*;
#(
  parameter int PRESCALE = 1024,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  swdStrobe_t       strobe,
  input  logic [1:0]       wrMode,
  input  logic             wrMgmtEn,
  input  logic [LEN_W-1:0] wrLen,
  input  logic [CNT_W-1:0] wrCnt,
  output logic [1:0]       modeNow,
  output logic             mgmtEnNow,
  output logic [LEN_W-1:0] lenNow,
  output logic [CNT_W-1:0] cntNow,
  output logic             expire
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int LOW_W = CNT_W - LEN_W;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] reloadVal;
  logic             running;
  logic             tick;

  // The length always feeds the top of the counter; any low bits reload as zero.
  generate
    if (LOW_W > 0) begin : g_lowZero
      assign reloadVal = {lenNow, {LOW_W{1'b0}}};
    end else begin : g_noLow
      assign reloadVal = lenNow;
    end
  endgenerate

  assign running = (modeNow != MODE_STOP);
  assign tick    = running && (preCnt == PRE_LAST);
  assign expire  = tick && (cntNow == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeNow   <= MODE_STOP;
      mgmtEnNow <= 1'b0;
      lenNow    <= '0;
      cntNow    <= '0;
      preCnt    <= '0;
    end else if (strobe.cfgLoad) begin
      modeNow   <= wrMode;
      mgmtEnNow <= wrMgmtEn;
      lenNow    <= wrLen;
      cntNow    <= wrCnt;
      preCnt    <= '0;
    end else if (strobe.goIdle) begin
      modeNow <= MODE_STOP;
      cntNow  <= '0;
      preCnt  <= '0;
    end else if (strobe.reload) begin
      cntNow <= reloadVal;
      preCnt <= '0;
    end else if (running) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick && (cntNow != '0)) begin
        cntNow <= cntNow - 1'b1;
      end
    end
  end

endmodule

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
#(
  parameter int TIMER_IDX = 0,
  parameter int ADDR_W    = 17,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic             pokeBit,
  input  logic             slotBit,
  input  logic             expire,
  input  logic [1:0]       modeNow,
  input  logic             mgmtEnNow,
  input  logic [LEN_W-1:0] lenNow,
  input  logic [CNT_W-1:0] cntNow,
  output swdStrobe_t       strobe,
  output logic [REG_W-1:0] busRdata,
  output logic             coreIrq,
  output logic             mgmtIrq,
  output logic             rstReq,
  output logic [1:0]       stageNow
);

  localparam int CNT_LSB = LEN_LSB + LEN_W;
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(TIMER_IDX * 8);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] ECLR_ADDR = ADDR_W'('h210);
  localparam logic [ADDR_W-1:0] ESET_ADDR = ADDR_W'('h218);
  localparam logic [ADDR_W-1:0] POKE_ADDR = ADDR_W'('h10000 + TIMER_IDX * 8);

  swdStage_t stage, stageNxt;
  logic      pend, enable;
  logic      wrStb, cfgWr, pokeWr, pendClr, enSet, enClr;
  logic      evt, firstHit, mgmtHit, finalHit;

  assign wrStb   = busValid && busWrite;
  assign cfgWr   = wrStb && (busAddr == CFG_ADDR);
  assign pokeWr  = wrStb && (busAddr == POKE_ADDR) && pokeBit;
  assign pendClr = wrStb && (busAddr == PEND_ADDR) && slotBit;
  assign enSet   = wrStb && (busAddr == ESET_ADDR) && slotBit;
  assign enClr   = wrStb && (busAddr == ECLR_ADDR) && slotBit;

  // A reload request in the same cycle cancels the expiry.
  assign evt      = expire && !pokeWr && !cfgWr;
  assign finalHit = evt && (modeNow == MODE_FULL) && (stage == STG_FINAL);
  assign firstHit = evt && ((modeNow == MODE_CORE) || (stage == STG_CORE));
  assign mgmtHit  = evt && (modeNow != MODE_CORE) && (stage == STG_MGMT);

  assign strobe.cfgLoad = cfgWr;
  assign strobe.reload  = pokeWr || (evt && !finalHit);
  assign strobe.goIdle  = finalHit;

  always_comb begin
    stageNxt = stage;
    if (cfgWr || pokeWr) begin
      stageNxt = STG_CORE;
    end else if (evt) begin
      if (modeNow == MODE_CORE) begin
        stageNxt = STG_CORE;
      end else begin
        unique case (stage)
          STG_CORE:  stageNxt = STG_MGMT;
          STG_MGMT:  stageNxt = (modeNow == MODE_FULL) ? STG_FINAL : STG_MGMT;
          default:   stageNxt = STG_CORE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage   <= STG_CORE;
      pend    <= 1'b0;
      enable  <= 1'b0;
      mgmtIrq <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      stage   <= stageNxt;
      // hardware set is applied after the software clear, so it wins
      pend    <= (pend && !pendClr) || firstHit;
      if (enSet) begin
        enable <= 1'b1;
      end else if (enClr) begin
        enable <= 1'b0;
      end
      mgmtIrq <= mgmtHit && mgmtEnNow;
      rstReq  <= finalHit;
    end
  end

  assign coreIrq  = pend && enable;
  assign stageNow = stage;

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      if (busAddr == CFG_ADDR) begin
        busRdata[MODE_LSB +: 2]     = modeNow;
        busRdata[MGMT_BIT]          = mgmtEnNow;
        busRdata[LEN_LSB +: LEN_W]  = lenNow;
        busRdata[CNT_LSB +: CNT_W]  = cntNow;
      end else if (busAddr == PEND_ADDR) begin
        busRdata[TIMER_IDX] = pend;
      end else if ((busAddr == ESET_ADDR) || (busAddr == ECLR_ADDR)) begin
        busRdata[TIMER_IDX] = enable;
      end
    end
  end

endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import swd_pkg::*;
#(
  parameter int TIMER_IDX = 0,
  parameter int PRESCALE  = 1024,
  parameter int ADDR_W    = 17,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              coreIrq,
  output logic              mgmtIrq,
  output logic              rstReq
);

  localparam int CNT_LSB = LEN_LSB + LEN_W;

  swdStrobe_t       strobe;
  logic [1:0]       modeNow;
  logic             mgmtEnNow;
  logic [LEN_W-1:0] lenNow;
  logic [CNT_W-1:0] cntNow;
  logic             expire;
  logic [1:0]       stageNow;
  logic             unusedWdata;

  assign unusedWdata = ^busWdata;

  swd_datapath #(
    .PRESCALE(PRESCALE),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrMode   (busWdata[MODE_LSB +: 2]),
    .wrMgmtEn (busWdata[MGMT_BIT]),
    .wrLen    (busWdata[LEN_LSB +: LEN_W]),
    .wrCnt    (busWdata[CNT_LSB +: CNT_W]),
    .modeNow  (modeNow),
    .mgmtEnNow(mgmtEnNow),
    .lenNow   (lenNow),
    .cntNow   (cntNow),
    .expire   (expire)
  );

  swd_ctrl #(
    .TIMER_IDX(TIMER_IDX),
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .pokeBit  (busWdata[0]),
    .slotBit  (busWdata[TIMER_IDX]),
    .expire   (expire),
    .modeNow  (modeNow),
    .mgmtEnNow(mgmtEnNow),
    .lenNow   (lenNow),
    .cntNow   (cntNow),
    .strobe   (strobe),
    .busRdata (busRdata),
    .coreIrq  (coreIrq),
    .mgmtIrq  (mgmtIrq),
    .rstReq   (rstReq),
    .stageNow (stageNow)
  );

endmodule

// File: rtl/stage_watchdog_chk.sv
module stage_watchdog_chk #(
  parameter int TIMER_IDX = 0,
  parameter int ADDR_W    = 17,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [63:0]       busWdata,
  input logic              coreIrq,
  input logic              mgmtIrq,
  input logic              rstReq,
  input logic [1:0]        modeNow,
  input logic [CNT_W-1:0]  cntNow,
  input logic [1:0]        stageNow
);

  localparam int LOW_W = CNT_W - LEN_W;
  localparam logic [ADDR_W-1:0] POKE_A = ADDR_W'('h10000 + TIMER_IDX * 8);

  logic pokeWr;
  logic anyWr;
  logic unusedChk;

  assign pokeWr    = busValid && busWrite && (busAddr == POKE_A) && busWdata[0];
  assign anyWr     = busValid && busWrite;
  assign unusedChk = ^{busWdata[63:1], coreIrq};

  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  assert_idle_after_rst_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (modeNow == 2'd0) && (cntNow == '0));

  assert_rst_from_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> ($past(modeNow) == 2'd3));

  assert_mgmt_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    mgmtIrq |=> !mgmtIrq);

  assert_poke_stage_R5: assert property (@(posedge clk) disable iff (!rstN)
    pokeWr |=> (stageNow == 2'd0) && (cntNow[LOW_W-1:0] == '0));

  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((modeNow == 2'd0) && !anyWr) |=> $stable(cntNow));

  assert_stage_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    stageNow != 2'd3);

endmodule

bind stage_watchdog stage_watchdog_chk #(
  .TIMER_IDX(TIMER_IDX),
  .ADDR_W   (ADDR_W),
  .LEN_W    (LEN_W),
  .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/stage_watchdog_tb.sv
module stage_watchdog_tb;

  localparam int IDX = 5;
  localparam int PRE = 4;
  localparam logic [16:0] A_CFG  = 17'h28;
  localparam logic [16:0] A_POKE = 17'h10028;
  localparam logic [16:0] A_PEND = 17'h200;
  localparam logic [16:0] A_ECLR = 17'h210;
  localparam logic [16:0] A_ESET = 17'h218;
  localparam logic [63:0] SLOT   = 64'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [16:0] busAddr = '0;
  logic [63:0] busWdata = '0;
  logic [63:0] busRdata;
  logic        coreIrq, mgmtIrq, rstReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int base = 0;
  int coreRiseCnt, coreRiseAt, mgmtCnt, mgmtAt, rstCnt, rstAt;
  logic corePrev = 1'b0;
  bit done = 1'b0;

  stage_watchdog #(.TIMER_IDX(IDX), .PRESCALE(PRE)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .coreIrq(coreIrq), .mgmtIrq(mgmtIrq), .rstReq(rstReq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (coreIrq && !corePrev) begin coreRiseCnt++; coreRiseAt = cyc; end
    corePrev = coreIrq;
    if (mgmtIrq) begin mgmtCnt++; mgmtAt = cyc; end
    if (rstReq) begin rstCnt++; rstAt = cyc; end
  end

  function automatic logic [63:0] cfgWord(input logic [1:0] m, input logic mg,
                                          input logic [15:0] l, input logic [23:0] c);
    return {20'b0, c, l, 1'b0, mg, m};
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [16:0] a, input logic [63:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busWdata = '0;
    #1;
  endtask

  task automatic busRd(input logic [16:0] a, output logic [63:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busValid = 1'b0;
    #1;
  endtask

  task automatic startCfg(input logic [63:0] w);
    busWr(A_CFG, w);
    base = cyc;
    coreRiseCnt = 0; coreRiseAt = -1;
    mgmtCnt = 0; mgmtAt = -1;
    rstCnt = 0; rstAt = -1;
  endtask

  task automatic waitUntil(input int k);
    while (cyc - base < k) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [63:0] rd;
    int t1, rl;
    t1 = (3 + 1) * PRE;          // first expiry with count 3
    rl = (256 * 1 + 1) * PRE;    // later expiries with length 1

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 outputs", {61'b0, coreIrq, mgmtIrq, rstReq}, 64'h0);
    busRd(A_CFG, rd);  chk("R11 cfg", rd, 64'h0);
    busRd(A_PEND, rd); chk("R11 pend", rd, 64'h0);

    // R1 / R2 readback and stopped hold
    startCfg(cfgWord(2'd0, 1'b1, 16'hABCD, 24'h123456));
    waitUntil(50);
    busRd(A_CFG, rd);
    chk("R1 cfg readback", rd, cfgWord(2'd0, 1'b1, 16'hABCD, 24'h123456));
    chk("R2 count held", rd[43:20], 64'h123456);
    busRd(17'h208, rd); chk("R11 unmapped", rd, 64'h0);
    busRd(A_POKE, rd);  chk("R11 poke read", rd, 64'h0);

    // R5 poke bit0 clear ignored, set reloads
    startCfg(cfgWord(2'd0, 1'b0, 16'h00AB, 24'd5));
    busWr(A_POKE, 64'h2);
    busRd(A_CFG, rd); chk("R5 poke bit0 clear", rd[43:20], 64'd5);
    busWr(A_POKE, 64'h1);
    busRd(A_CFG, rd); chk("R4 poke reload", rd[43:20], 64'hAB00);

    // R10 enable set
    busWr(A_ESET, SLOT);
    busRd(A_ESET, rd); chk("R10 enable read set", rd, SLOT);
    busRd(A_ECLR, rd); chk("R10 enable read clr", rd, SLOT);

    // R6 full sequence with mgmt interrupt
    busWr(A_PEND, SLOT);
    startCfg(cfgWord(2'd3, 1'b1, 16'd1, 24'd3));
    waitUntil(t1 + 2 * rl + 5);
    chk("R3 first expiry", 64'(coreRiseAt - base), 64'(t1));
    chk("R6 mgmt count", 64'(mgmtCnt), 64'd1);
    chk("R6 mgmt time", 64'(mgmtAt - base), 64'(t1 + rl));
    chk("R6 reset count", 64'(rstCnt), 64'd1);
    chk("R6 reset time", 64'(rstAt - base), 64'(t1 + 2 * rl));
    busRd(A_CFG, rd);
    chk("R6 idle mode", rd[1:0], 64'd0);
    chk("R6 idle count", rd[43:20], 64'd0);
    waitUntil(t1 + 2 * rl + 40);
    chk("R6 single reset", 64'(rstCnt), 64'd1);
    chk("R10 core level", 64'(coreIrq), 64'd1);
    busWr(A_ECLR, SLOT);
    chk("R10 enable cleared", 64'(coreIrq), 64'd0);
    busRd(A_ESET, rd); chk("R10 enable read", rd, 64'h0);
    busWr(A_ESET, SLOT);
    chk("R10 enable set again", 64'(coreIrq), 64'd1);
    busWr(A_PEND, SLOT);
    chk("R9 pending cleared", 64'(coreIrq), 64'd0);

    // R7 mgmt interrupt disabled
    startCfg(cfgWord(2'd3, 1'b0, 16'd1, 24'd3));
    waitUntil(t1 + 2 * rl + 5);
    chk("R7 no mgmt pulse", 64'(mgmtCnt), 64'd0);
    chk("R7 reset time", 64'(rstAt - base), 64'(t1 + 2 * rl));
    busWr(A_PEND, SLOT);

    // R8 mode 1
    startCfg(cfgWord(2'd1, 1'b1, 16'd1, 24'd3));
    waitUntil(t1 + 1);
    busRd(A_CFG, rd); chk("R4 reload after expiry", rd[43:20], 64'h100);
    chk("R3 mode1 first expiry", 64'(coreRiseAt - base), 64'(t1));
    busWr(A_PEND, SLOT);
    chk("R9 clear mode1", 64'(coreIrq), 64'd0);
    waitUntil(t1 + rl + 3);
    chk("R8 mode1 re-set time", 64'(coreRiseAt - base), 64'(t1 + rl));
    chk("R8 mode1 rises", 64'(coreRiseCnt), 64'd2);
    waitUntil(t1 + 2 * rl + 3);
    chk("R8 mode1 no mgmt/reset", 64'(mgmtCnt + rstCnt), 64'd0);
    busRd(A_CFG, rd); chk("R8 mode1 kept", rd[1:0], 64'd1);
    busWr(A_PEND, SLOT);

    // R8 mode 2
    startCfg(cfgWord(2'd2, 1'b1, 16'd1, 24'd3));
    waitUntil(t1 + 2 * rl + 5);
    chk("R8 mode2 core", 64'(coreRiseAt - base), 64'(t1));
    chk("R8 mode2 mgmt count", 64'(mgmtCnt), 64'd2);
    chk("R8 mode2 mgmt time", 64'(mgmtAt - base), 64'(t1 + 2 * rl));
    chk("R8 mode2 no reset", 64'(rstCnt), 64'd0);
    busWr(A_PEND, SLOT);

    // R5 poke returns stage to first
    startCfg(cfgWord(2'd3, 1'b1, 16'd1, 24'd3));
    waitUntil(t1 + 10);
    busWr(A_POKE, 64'h1);
    busRd(A_CFG, rd); chk("R5 poke count", rd[43:20], 64'h100);
    waitUntil(t1 + rl + 50);
    chk("R5 stage restarted", 64'(mgmtCnt + rstCnt), 64'd0);
    busWr(A_PEND, SLOT);

    // R9 hardware set wins over same-cycle clear
    startCfg(cfgWord(2'd1, 1'b0, 16'd1, 24'd3));
    repeat (t1 - 2) @(negedge clk);
    busWr(A_PEND, SLOT);
    busRd(A_PEND, rd); chk("R9 set wins", rd, SLOT);

    busWr(A_CFG, 64'h0);
    finishRun();
  end

endmodule